// File: doc/BRIEF.md
# Dual Clock Source Control Register Unit

This unit is the bus-facing register logic for a clock system with two sources: an on-chip generator whose frequency is set by a multiplier, and an off-chip oscillator. It holds an enable for each source and the 7-bit frequency multiplier. It also reports one read-only stability flag per source. Software reaches it through a two-location register port. The clock-select and monitor-enable bits from the neighbouring switch logic decide when software may turn a source off and when the hardware forces a source back on.

The internal stability flag follows the generator's lock output. Several events drop it at once: a dead-clock report from the monitor, a disabled generator, a multiplier or trim update, and stop mode without oscillator retention. The external stability flag comes from a start-up counter that runs on the external clock. The counter stops at its terminal count. Its done flag crosses into the bus clock through a synchronizer. Any condition that invalidates the external clock holds the counter at zero.

Top module: `clksrc_ctrl`

## Requirements
- R1: The internal enable (address 0, bit 0) is set by writing 1. A written 0 clears it only if `cs_sel`=1 and `cmon_en`=0 at that edge and also at the bus edge before it; otherwise the 0 is ignored.
- R2: The internal enable reads 1 after reset. It is set at the next bus edge whenever `cmon_en`=1 or `cs_sel`=0, whatever is written.
- R3: The external enable (address 0, bit 2) is set by writing 1. A written 0 clears it only if `cs_sel`=0 and `cmon_en`=0 at that edge and also at the bus edge before it.
- R4: The external enable reads 0 after reset. It is set at the next bus edge whenever `cs_sel`=1 or `cmon_en`=1.
- R5: The internal stable flag (address 0, bit 1) is 0 after reset. At each bus edge it takes the value of `int_lock`. It is loaded with 0 instead when any of these holds: the internal enable is 0, `int_clk_dead` is 1, `trim_wr` is 1, an accepted multiplier write occurs, or `stop_mode`=1 with `osc_in_stop`=0.
- R6: The multiplier reads at address 1 in bits 6:0, and bit 7 reads 0. Reset loads 0x15. Address 0 bits 7:4 read 0.
- R7: `mult_out` equals the stored multiplier, except that a stored 0x00 is presented as 0x01.
- R8: A write to address 1 while `cmon_en`=1 leaves the multiplier unchanged.
- R9: The external stable flag (address 0, bit 3) rises on the second bus edge after the 4096th external clock rising edge counted since the hold was released. Further external edges keep it at 1.
- R10: The external stable flag is forced to 0 after the bus edge where any of these is sampled: `ext_clk_dead`=1, the external enable is 0, or `stop_mode`=1 with `osc_in_stop`=0. The count then restarts from zero. `stop_mode` with `osc_in_stop`=1 does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External oscillator clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control/status, 1 = multiplier |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cs_sel | input | 1 | Clock select (1 = external source in use) |
| cmon_en | input | 1 | Clock monitoring active |
| int_clk_dead | input | 1 | Monitor reports internal clock inactive |
| ext_clk_dead | input | 1 | Monitor reports external clock inactive |
| int_lock | input | 1 | Frequency comparator lock |
| stop_mode | input | 1 | Stop mode active |
| osc_in_stop | input | 1 | Oscillators kept running in stop mode |
| trim_wr | input | 1 | Trim register write strobe |
| int_en | output | 1 | Internal generator enable |
| ext_en | output | 1 | External generator enable |
| int_stable | output | 1 | Internal clock stable |
| ext_stable | output | 1 | External clock start-up delay elapsed |
| mult_out | output | 7 | Multiplier presented to the generator |

## Verification
The bench builds the unit with its default parameters: a 7-bit multiplier resetting to 21, a 4096-edge start-up count and a two-stage synchronizer. The bench places each external edge at a falling bus edge. This makes the synchronizer latency exact, so the flag can be checked one edge before and at the edge it rises after the 4096th external pulse. The full count is repeated for each way of clearing the external flag. A seeded random phase stresses the enable qualifiers, the multiplier block and the internal flag clears against a model built from the requirements.

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl #(
  parameter int MULT_W    = 7,
  parameter int MULT_RST  = 21,
  parameter int START_CNT = 4096,
  parameter int SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              cs_sel,
  input  logic              cmon_en,
  input  logic              int_clk_dead,
  input  logic              ext_clk_dead,
  input  logic              int_lock,
  input  logic              stop_mode,
  input  logic              osc_in_stop,
  input  logic              trim_wr,
  output logic              int_en,
  output logic              ext_en,
  output logic              int_stable,
  output logic              ext_stable,
  output logic [MULT_W-1:0] mult_out
);
  localparam int CW = $clog2(START_CNT + 1);
  localparam logic [CW-1:0] CNT_END = CW'(START_CNT);

  logic [MULT_W-1:0] mult_q;
  logic              int_ok_q, ext_ok_q, ext_hold;
  logic [CW-1:0]     cnt;
  logic [SYNC_N-1:0] sync_q;

  wire ctrl_wr  = wr_en && !addr;
  wire mult_wr  = wr_en && addr && !cmon_en;
  wire int_ok   = cs_sel && !cmon_en;
  wire ext_ok   = !cs_sel && !cmon_en;
  wire stop_off = stop_mode && !osc_in_stop;
  wire int_clr  = !int_en || int_clk_dead || mult_wr || trim_wr || stop_off;
  wire ext_clr  = !ext_en || ext_clk_dead || stop_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_ok_q <= 1'b0;
      ext_ok_q <= 1'b0;
    end else begin
      int_ok_q <= int_ok;
      ext_ok_q <= ext_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      int_en <= 1'b1;
    else if (!cs_sel || cmon_en)
      int_en <= 1'b1;
    else if (ctrl_wr && wdata[0])
      int_en <= 1'b1;
    else if (ctrl_wr && int_ok && int_ok_q)
      int_en <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ext_en <= 1'b0;
    else if (cs_sel || cmon_en)
      ext_en <= 1'b1;
    else if (ctrl_wr && wdata[2])
      ext_en <= 1'b1;
    else if (ctrl_wr && ext_ok && ext_ok_q)
      ext_en <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mult_q <= MULT_W'(MULT_RST);
    else if (mult_wr)
      mult_q <= wdata[MULT_W-1:0];
  end

  assign mult_out = (mult_q == '0) ? MULT_W'(1) : mult_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      int_stable <= 1'b0;
    else
      int_stable <= int_lock && !int_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ext_hold <= 1'b1;
    else
      ext_hold <= ext_clr;
  end

  always_ff @(posedge ext_clk or posedge ext_hold) begin
    if (ext_hold)
      cnt <= '0;
    else if (cnt != CNT_END)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or posedge ext_hold) begin
    if (ext_hold)
      sync_q <= '0;
    else
      sync_q <= {sync_q[SYNC_N-2:0], cnt == CNT_END};
  end

  assign ext_stable = sync_q[SYNC_N-1];

  assign rdata = addr ? 8'(mult_q)
                      : {4'b0000, ext_stable, ext_en, int_stable, int_en};
endmodule

// File: rtl/clksrc_ctrl_chk.sv
module clksrc_ctrl_chk #(
  parameter int MULT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_sel,
  input logic              cmon_en,
  input logic              int_clk_dead,
  input logic              ext_clk_dead,
  input logic              int_lock,
  input logic              stop_mode,
  input logic              osc_in_stop,
  input logic              trim_wr,
  input logic              int_en,
  input logic              ext_en,
  input logic              int_stable,
  input logic              ext_stable,
  input logic [MULT_W-1:0] mult_out
);
  AST_INT_CLR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_en) |-> ($past(cs_sel && !cmon_en, 1) && $past(cs_sel && !cmon_en, 2))); // R1
  AST_INT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_sel || cmon_en) |=> int_en); // R2
  AST_EXT_CLR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_en) |-> ($past(!cs_sel && !cmon_en, 1) && $past(!cs_sel && !cmon_en, 2))); // R3
  AST_EXT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel || cmon_en) |=> ext_en); // R4
  AST_INT_STB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_lock || !int_en || int_clk_dead || trim_wr || (stop_mode && !osc_in_stop)) |=> !int_stable); // R5
  AST_MULT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mult_out != '0); // R7
  AST_MULT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cmon_en |=> $stable(mult_out)); // R8
  AST_EXT_STB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en || ext_clk_dead || (stop_mode && !osc_in_stop)) |=> !ext_stable); // R10
endmodule

bind clksrc_ctrl clksrc_ctrl_chk #(.MULT_W(MULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_sel(cs_sel), .cmon_en(cmon_en),
  .int_clk_dead(int_clk_dead), .ext_clk_dead(ext_clk_dead), .int_lock(int_lock),
  .stop_mode(stop_mode), .osc_in_stop(osc_in_stop), .trim_wr(trim_wr),
  .int_en(int_en), .ext_en(ext_en), .int_stable(int_stable),
  .ext_stable(ext_stable), .mult_out(mult_out)
);

// File: tb/clksrc_ctrl_test.sv
`timescale 1ns/1ps
module clksrc_ctrl_test;
  logic clk = 0, rst_n = 0, ext_clk = 0;
  logic wr_en = 0, addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic cs_sel = 0, cmon_en = 0, int_clk_dead = 0, ext_clk_dead = 0;
  logic int_lock = 0, stop_mode = 0, osc_in_stop = 0, trim_wr = 0;
  logic int_en, ext_en, int_stable, ext_stable;
  logic [6:0] mult_out;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  clksrc_ctrl uut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    addr = a; #1 d = rdata; addr = 0;
  endtask

  task automatic ext_pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1; #5 ext_clk = 0;
    end
  endtask

  task automatic count_up(string tag);
    ext_pulse(4095);
    cyc(3);
    chk({tag, " before 4096th edge"}, {7'd0, ext_stable}, 8'd0);
    ext_pulse(1);
    @(posedge clk); #1;
    chk({tag, " one edge after 4096th"}, {7'd0, ext_stable}, 8'd0);
    @(posedge clk); #1;
    chk({tag, " two edges after 4096th"}, {7'd0, ext_stable}, 8'd1);
  endtask

  function automatic logic [6:0] map_mult(logic [6:0] m);
    return (m == 0) ? 7'd1 : m;
  endfunction

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic m_int, m_ext, m_ist, m_qi, m_qe, n_int, n_ext, n_ist, wc, wm, ic;
    logic [6:0] m_mult, n_mult;
    void'($urandom(32'd20240611));
    cyc(3); rst_n = 1; cyc(1);

    rd(0, d); chk("R2 R4 reset ctrl", d, 8'h01);
    rd(1, d); chk("R6 reset mult", d, 8'h15);
    chk("R7 reset mult_out", {1'b0, mult_out}, 8'h15);

    wr(0, 8'h00); rd(0, d); chk("R2 cs=0 write 0 ignored", d, 8'h01);
    cs_sel = 1; cyc(1); rd(0, d); chk("R4 cs=1 forces ext", d, 8'h05);
    cs_sel = 0; cyc(1);
    @(negedge clk); cs_sel = 1; wr_en = 1; wdata = 8'h04;
    @(negedge clk); wr_en = 0;
    rd(0, d); chk("R1 clear blocked without prior cycle", d, 8'h05);
    wr(0, 8'h04); rd(0, d); chk("R1 qualified clear", d, 8'h04);
    wr(0, 8'h05); rd(0, d); chk("R1 write 1 sets", d, 8'h05);
    wr(0, 8'h04); cmon_en = 1; cyc(1); rd(0, d); chk("R2 cmon forces int", d, 8'h05);

    wr(1, 8'h33); rd(1, d); chk("R8 write blocked by cmon", d, 8'h15);
    cmon_en = 0; cyc(1);
    wr(1, 8'h80); rd(1, d); chk("R6 bit7 reads 0", d, 8'h00);
    chk("R7 zero mapped to one", {1'b0, mult_out}, 8'h01);
    wr(1, 8'h7f); chk("R7 full value", {1'b0, mult_out}, 8'h7f);

    @(negedge clk); cs_sel = 0; wr_en = 1; wdata = 8'h01;
    @(negedge clk); wr_en = 0;
    rd(0, d); chk("R3 clear blocked without prior cycle", d, 8'h05);
    wr(0, 8'h01); rd(0, d); chk("R3 qualified clear", d, 8'h01);
    cmon_en = 1; cyc(1); rd(0, d); chk("R4 cmon forces ext", d, 8'h05);
    cmon_en = 0; cyc(1);

    int_lock = 1; cyc(1); chk("R5 follows lock", {7'd0, int_stable}, 8'd1);
    trim_wr = 1; cyc(1); trim_wr = 0; chk("R5 trim clears", {7'd0, int_stable}, 8'd0);
    cyc(1); chk("R5 recovers", {7'd0, int_stable}, 8'd1);
    wr(1, 8'h15); chk("R5 mult write clears", {7'd0, int_stable}, 8'd0);
    cyc(1);
    int_clk_dead = 1; cyc(1); int_clk_dead = 0; chk("R5 dead clears", {7'd0, int_stable}, 8'd0);
    stop_mode = 1; osc_in_stop = 1; cyc(2); chk("R5 stop with osc kept", {7'd0, int_stable}, 8'd1);
    osc_in_stop = 0; cyc(1); chk("R5 stop clears", {7'd0, int_stable}, 8'd0);
    stop_mode = 0; cyc(1);
    int_lock = 0; cyc(1); chk("R5 lock low", {7'd0, int_stable}, 8'd0);
    int_lock = 1; cs_sel = 1; cyc(2); wr(0, 8'h04); cyc(1);
    chk("R5 disabled clears", {7'd0, int_stable}, 8'd0);

    m_int = int_en; m_ext = ext_en; m_ist = int_stable;
    rd(1, d); m_mult = d[6:0];
    m_qi = cs_sel && !cmon_en; m_qe = !cs_sel && !cmon_en;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) cs_sel = $urandom_range(1);
      if ($urandom_range(3) == 0) cmon_en = ($urandom_range(2) == 0);
      wr_en = $urandom_range(1); addr = $urandom_range(1);
      wdata = ($urandom_range(1) == 0) ? 8'h00 : 8'($urandom);
      int_lock = ($urandom_range(4) != 0);
      int_clk_dead = ($urandom_range(9) == 0);
      trim_wr = ($urandom_range(9) == 0);
      stop_mode = ($urandom_range(7) == 0); osc_in_stop = $urandom_range(1);
      wc = wr_en && !addr; wm = wr_en && addr && !cmon_en;
      n_int = (!cs_sel || cmon_en) ? 1'b1 : (wc && wdata[0]) ? 1'b1 :
              (wc && cs_sel && !cmon_en && m_qi) ? 1'b0 : m_int;
      n_ext = (cs_sel || cmon_en) ? 1'b1 : (wc && wdata[2]) ? 1'b1 :
              (wc && !cs_sel && !cmon_en && m_qe) ? 1'b0 : m_ext;
      n_mult = wm ? wdata[6:0] : m_mult;
      ic = !m_int || int_clk_dead || wm || trim_wr || (stop_mode && !osc_in_stop);
      n_ist = int_lock && !ic;
      @(posedge clk); #1;
      m_int = n_int; m_ext = n_ext; m_mult = n_mult; m_ist = n_ist;
      m_qi = cs_sel && !cmon_en; m_qe = !cs_sel && !cmon_en;
      chk("R1 R2 random int_en", {7'd0, int_en}, {7'd0, m_int});
      chk("R3 R4 random ext_en", {7'd0, ext_en}, {7'd0, m_ext});
      chk("R5 random int_stable", {7'd0, int_stable}, {7'd0, m_ist});
      chk("R7 R8 random mult_out", {1'b0, mult_out}, {1'b0, map_mult(m_mult)});
    end
    @(negedge clk);
    wr_en = 0; addr = 0; int_clk_dead = 0; trim_wr = 0; stop_mode = 0;
    osc_in_stop = 0; cs_sel = 1; cmon_en = 0;
    cyc(3);

    count_up("R9");
    ext_pulse(20); cyc(2); chk("R9 saturates", {7'd0, ext_stable}, 8'd1);
    ext_clk_dead = 1; cyc(1); ext_clk_dead = 0;
    chk("R10 dead clears", {7'd0, ext_stable}, 8'd0);
    cyc(5); chk("R10 stays clear", {7'd0, ext_stable}, 8'd0);
    count_up("R10 after dead");
    stop_mode = 1; osc_in_stop = 1; cyc(3);
    chk("R10 stop with osc kept", {7'd0, ext_stable}, 8'd1);
    osc_in_stop = 0; cyc(1); stop_mode = 0;
    chk("R10 stop clears", {7'd0, ext_stable}, 8'd0);
    count_up("R10 after stop");
    cs_sel = 0; cyc(2); wr(0, 8'h01); cyc(1);
    chk("R10 disable clears", {7'd0, ext_stable}, 8'd0);
    rd(0, d); chk("R6 ctrl upper bits zero", {d[7:4], 4'd0}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule